// File: doc/BRIEF.md
# Predicated Vector Load Address Sequencer

This block turns one vector load into a stream of per-element memory requests. A start strobe captures the vector length, an addressing mode, an access-width code, a signed immediate, a scalar base value, an update flag and two predicate masks: one for the source (address) side and one for the destination (register) side. The block then walks both masks on their own. It pairs the k-th enabled source position with the k-th enabled destination position and issues one effective address per pair over a valid/ready handshake.

There are four ways to form the address. Indirect mode takes a per-element base, which the block asks for by driving the source element index and reading the value back in the same cycle. Element-stride mode scales the immediate by the element index. Unit-stride mode scales the access size by the element index. Splat mode reuses one address for every element. When the update flag is set, every accepted request also raises a base-writeback strobe that carries the address. In the stride and splat modes the caller's single base therefore ends up holding the address of the last element issued. Memory, register storage and returned data stay outside the block. It reports the end of the sequence with a one-cycle done pulse.

Top module: `vld_addr_seq`

## Requirements
- R1: In unit-stride mode (mode code 2), element i's address is base + i × size, where size is 1, 2, 4 or 8 bytes for width codes 0, 1, 2, 3.
- R2: In indirect mode (mode code 0), `src_idx` carries the source element index, and the address is the `ind_base` value returned for that index plus the sign-extended immediate.
- R3: In element-stride mode (mode code 1), element i's address is base + i × sign-extended immediate.
- R4: In splat mode (mode code 3), every element's address is base + sign-extended immediate, whatever the index.
- R5: Source positions whose `src_mask` bit is 0 and destination positions whose `dst_mask` bit is 0 are skipped independently. The k-th request pairs the k-th set source bit with the k-th set destination bit, and both indices rise strictly from one request to the next.
- R6: The sequence ends as soon as the next enabled source index or destination index would reach the vector length. `done` is then high for exactly one cycle, no further request is issued, and `busy` is low on the following cycle.
- R7: A vector length of 0 gives `done` in the first cycle after the start edge, with no request.
- R8: While `req_valid` is high and `req_ready` is low, the request is held with the same address and destination index in the next cycle.
- R9: With the update flag set, each accepted request raises `wb_valid` together with `wb_addr` equal to the request address. `wb_elem` is the source index in indirect mode and 0 otherwise, so the last writeback carries the last element's address. With the flag clear, `wb_valid` stays low.
- R10: A start strobe received while `busy` is high is ignored, and the sequence in progress continues unchanged.
- R11: The immediate is sign-extended before any addition or multiplication, and address arithmetic wraps modulo 2^64.
- R12: After reset the block is idle: `busy`, `req_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| vl | input | 7 | Vector length, 0 to 64 |
| mode | input | 2 | 0 indirect, 1 element stride, 2 unit stride, 3 splat |
| width_code | input | 2 | Access size code: 1, 2, 4 or 8 bytes |
| imm | input | 16 | Signed immediate |
| base_val | input | 64 | Scalar base value |
| upd_en | input | 1 | Enable base writeback |
| src_mask | input | 64 | Source-side predicate |
| dst_mask | input | 64 | Destination-side predicate |
| src_idx | output | 6 | Source element index in use (per-element base lookup) |
| ind_base | input | 64 | Per-element base for `src_idx`, same cycle |
| req_valid | output | 1 | Address request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 64 | Effective address |
| req_dst_idx | output | 6 | Destination element index |
| wb_valid | output | 1 | Base writeback strobe |
| wb_elem | output | 6 | Base register element written back |
| wb_addr | output | 64 | Writeback value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
On every cycle the assertions check the handshake hold under backpressure, that every issued index pair lies on set bits of the captured masks and below the captured length, that the indices strictly advance after each acceptance, that writebacks occur only on accepted requests, and that the zero-length case and the end of the sequence behave as specified. The arithmetic itself can only be shown by the bench's scenarios, which compare each address against a model: the four mode formulas, sign extension, wraparound past 2^64, the pairing of the k-th source bit with the k-th destination bit, the final writeback value, and the refusal of a start during a run.

// File: rtl/vld_seq_pkg.sv
package vld_seq_pkg;

   typedef enum logic [1:0] {
      AM_INDIRECT = 2'd0,
      AM_ESTRIDE  = 2'd1,
      AM_USTRIDE  = 2'd2,
      AM_SPLAT    = 2'd3
   } amode_e;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/vld_first_set.sv
// Finds the lowest set mask bit at or above a starting position.
module vld_first_set #(
   parameter  int N  = 64,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0] mask,
   input  logic [IW:0]  lo,
   output logic         found,
   output logic [IW-1:0] pos
);

   if (N < 2 || (1 << IW) != N) begin : g_bad_n
      $error("vld_first_set: N must be a power of two, at least 2");
   end

   logic [N-1:0] keep;

   for (genvar g = 0; g < N; g++) begin : g_keep
      localparam logic [IW:0] GI = g;
      assign keep[g] = mask[g] && (GI >= lo);
   end

   always_comb begin
      found = |keep;
      pos   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (keep[k]) pos = IW'(k);
      end
   end

endmodule

// File: rtl/vld_addr_gen.sv
// Effective address for one element under the selected mode.
module vld_addr_gen
   import vld_seq_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int IMM_W  = 16,
   parameter int IDX_W  = 6
) (
   input  amode_e             mode,
   input  logic [1:0]         width_code,
   input  logic [IMM_W-1:0]   imm,
   input  logic [ADDR_W-1:0]  base,
   input  logic [ADDR_W-1:0]  ind_base,
   input  logic [IDX_W-1:0]   idx,
   output logic [ADDR_W-1:0]  addr
);

   if (IMM_W >= ADDR_W || IDX_W >= ADDR_W) begin : g_bad_w
      $error("vld_addr_gen: immediate and index must be narrower than the address");
   end

   logic [ADDR_W-1:0] imm_sx;
   logic [ADDR_W-1:0] idx_w;

   assign imm_sx = {{(ADDR_W - IMM_W){imm[IMM_W-1]}}, imm};
   assign idx_w  = ADDR_W'(idx);

   always_comb begin
      unique case (mode)
         AM_INDIRECT: addr = ind_base + imm_sx;
         AM_ESTRIDE:  addr = base + idx_w * imm_sx;
         AM_USTRIDE:  addr = base + (idx_w << width_code);
         default:     addr = base + imm_sx;
      endcase
   end

endmodule

// File: rtl/vld_addr_seq.sv
// Predicated vector load address sequencer (top).
module vld_addr_seq
   import vld_seq_pkg::*;
#(
   parameter  int ADDR_W = 64,
   parameter  int IMM_W  = 16,
   parameter  int MAX_VL = 64,
   localparam int IDX_W  = $clog2(MAX_VL),
   localparam int CNT_W  = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  vl,
   input  logic [1:0]        mode,
   input  logic [1:0]        width_code,
   input  logic [IMM_W-1:0]  imm,
   input  logic [ADDR_W-1:0] base_val,
   input  logic              upd_en,
   input  logic [MAX_VL-1:0] src_mask,
   input  logic [MAX_VL-1:0] dst_mask,
   output logic [IDX_W-1:0]  src_idx,
   input  logic [ADDR_W-1:0] ind_base,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [IDX_W-1:0]  req_dst_idx,
   output logic              wb_valid,
   output logic [IDX_W-1:0]  wb_elem,
   output logic [ADDR_W-1:0] wb_addr,
   output logic              busy,
   output logic              done
);

   if (MAX_VL < 2 || (1 << IDX_W) != MAX_VL) begin : g_bad_vl
      $error("vld_addr_seq: MAX_VL must be a power of two, at least 2");
   end
   if (ADDR_W < 8 || IMM_W < 2 || IMM_W >= ADDR_W) begin : g_bad_w
      $error("vld_addr_seq: need 2 <= IMM_W < ADDR_W and ADDR_W >= 8");
   end

   // captured operation
   seq_state_e        state_q;
   logic [CNT_W-1:0]  si_q, dj_q, vl_q;
   amode_e            mode_q;
   logic [1:0]        wc_q;
   logic [IMM_W-1:0]  imm_q;
   logic [ADDR_W-1:0] base_q;
   logic              upd_q;
   logic [MAX_VL-1:0] smask_q, dmask_q;

   // scan results
   logic              s_found, d_found;
   logic [IDX_W-1:0]  s_pos, d_pos;
   logic              running, elem_ok, fire;
   logic [ADDR_W-1:0] eff_addr;
   logic [CNT_W-1:0]  s_next, d_next;

   vld_first_set #(.N(MAX_VL)) u_src_find (
      .mask  (smask_q),
      .lo    (si_q),
      .found (s_found),
      .pos   (s_pos)
   );

   vld_first_set #(.N(MAX_VL)) u_dst_find (
      .mask  (dmask_q),
      .lo    (dj_q),
      .found (d_found),
      .pos   (d_pos)
   );

   vld_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_agen (
      .mode       (mode_q),
      .width_code (wc_q),
      .imm        (imm_q),
      .base       (base_q),
      .ind_base   (ind_base),
      .idx        (s_pos),
      .addr       (eff_addr)
   );

   assign running = (state_q == SQ_RUN);
   assign elem_ok = running && s_found && d_found &&
                    ({1'b0, s_pos} < vl_q) && ({1'b0, d_pos} < vl_q);
   assign fire    = elem_ok && req_ready;
   assign s_next  = {1'b0, s_pos} + CNT_W'(1);
   assign d_next  = {1'b0, d_pos} + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         si_q    <= '0;
         dj_q    <= '0;
         vl_q    <= '0;
         mode_q  <= AM_INDIRECT;
         wc_q    <= '0;
         imm_q   <= '0;
         base_q  <= '0;
         upd_q   <= 1'b0;
         smask_q <= '0;
         dmask_q <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  state_q <= SQ_RUN;
                  si_q    <= '0;
                  dj_q    <= '0;
                  vl_q    <= vl;
                  mode_q  <= amode_e'(mode);
                  wc_q    <= width_code;
                  imm_q   <= imm;
                  base_q  <= base_val;
                  upd_q   <= upd_en;
                  smask_q <= src_mask;
                  dmask_q <= dst_mask;
               end
            end
            default: begin
               if (fire) begin
                  si_q <= s_next;
                  dj_q <= d_next;
               end else if (!elem_ok) begin
                  state_q <= SQ_IDLE;
               end
            end
         endcase
      end
   end

   assign src_idx     = s_pos;
   assign req_valid   = elem_ok;
   assign req_addr    = eff_addr;
   assign req_dst_idx = d_pos;
   assign wb_valid    = fire && upd_q;
   assign wb_elem     = (mode_q == AM_INDIRECT) ? s_pos : '0;
   assign wb_addr     = eff_addr;
   assign busy        = running;
   assign done        = running && !elem_ok;

endmodule

// File: rtl/vld_addr_seq_chk.sv
// Property checker bound to the sequencer.
module vld_addr_seq_chk #(
   parameter  int ADDR_W = 64,
   parameter  int MAX_VL = 64,
   localparam int IDX_W  = $clog2(MAX_VL),
   localparam int CNT_W  = IDX_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  vl,
   input logic [MAX_VL-1:0] src_mask,
   input logic [MAX_VL-1:0] dst_mask,
   input logic              busy,
   input logic              done,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [IDX_W-1:0]  req_dst_idx,
   input logic [IDX_W-1:0]  src_idx,
   input logic              wb_valid
);

   logic [MAX_VL-1:0] sm_c, dm_c;
   logic [CNT_W-1:0]  vl_c;
   logic              hs;

   assign hs = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sm_c <= '0;
         dm_c <= '0;
         vl_c <= '0;
      end else if (start && !busy) begin
         sm_c <= src_mask;
         dm_c <= dst_mask;
         vl_c <= vl;
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_dst_idx)); // R8

   AST_PRED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> sm_c[src_idx] && dm_c[req_dst_idx]); // R5

   AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      hs |=> !req_valid || (req_dst_idx > $past(req_dst_idx) && src_idx > $past(src_idx))); // R5

   AST_IDX_BELOW_VL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ({1'b0, src_idx} < vl_c) && ({1'b0, req_dst_idx} < vl_c)); // R6

   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy && !done); // R6

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && vl == '0 |=> done && !req_valid); // R7

   AST_WB_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> hs); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid && !done); // R12

endmodule

bind vld_addr_seq vld_addr_seq_chk #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .vl          (vl),
   .src_mask    (src_mask),
   .dst_mask    (dst_mask),
   .busy        (busy),
   .done        (done),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_addr    (req_addr),
   .req_dst_idx (req_dst_idx),
   .src_idx     (src_idx),
   .wb_valid    (wb_valid)
);

// File: tb/vld_addr_seq_tb_top.sv
`timescale 1ns/1ps
module vld_addr_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  vl_i = '0;
   logic [1:0]  mode_i = '0;
   logic [1:0]  wc_i = '0;
   logic [15:0] imm_i = '0;
   logic [63:0] base_i = '0;
   logic        upd_i = 1'b0;
   logic [63:0] sm_i = '0;
   logic [63:0] dm_i = '0;
   logic [5:0]  src_idx;
   logic [63:0] ind_base;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [63:0] req_addr;
   logic [5:0]  req_dst_idx;
   logic        wb_valid;
   logic [5:0]  wb_elem;
   logic [63:0] wb_addr;
   logic        busy;
   logic        done;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   function automatic logic [63:0] ibase_of(input logic [5:0] idx);
      return 64'hC000_0000_0000_0000 ^ (64'(idx) * 64'h0000_0001_0000_1011);
   endfunction

   assign ind_base = ibase_of(src_idx);

   vld_addr_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .vl(vl_i), .mode(mode_i),
      .width_code(wc_i), .imm(imm_i), .base_val(base_i), .upd_en(upd_i),
      .src_mask(sm_i), .dst_mask(dm_i), .src_idx(src_idx), .ind_base(ind_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_dst_idx(req_dst_idx), .wb_valid(wb_valid), .wb_elem(wb_elem),
      .wb_addr(wb_addr), .busy(busy), .done(done)
   );

   // expected sequence
   logic [63:0] e_addr [64];
   int          e_dst [64];
   int          e_src [64];
   int          e_n;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic build(input int vl, input int mode, input int wc, input logic [15:0] imm,
                        input logic [63:0] base, input logic [63:0] sm, input logic [63:0] dm);
      int si = 0;
      int dj = 0;
      logic [63:0] isx = {{48{imm[15]}}, imm};
      e_n = 0;
      forever begin
         while (si < vl && !sm[si]) si++;
         while (dj < vl && !dm[dj]) dj++;
         if (si >= vl || dj >= vl) break;
         case (mode)
            0: e_addr[e_n] = ibase_of(6'(si)) + isx;
            1: e_addr[e_n] = base + 64'(si) * isx;
            2: e_addr[e_n] = base + 64'(si) * (64'd1 << wc);
            default: e_addr[e_n] = base + isx;
         endcase
         e_src[e_n] = si;
         e_dst[e_n] = dj;
         e_n++;
         si++;
         dj++;
      end
   endtask

   function automatic string mode_tag(input int mode);
      case (mode)
         0: return "R2";
         1: return "R3";
         2: return "R1";
         default: return "R4";
      endcase
   endfunction

   task automatic run_op(input int vl, input int mode, input int wc, input logic [15:0] imm,
                         input logic [63:0] base, input logic [63:0] sm, input logic [63:0] dm,
                         input bit upd, input int rdy_pct, input bit poke, input string atag);
      int k = 0;
      bit fin = 0;
      int done_cyc = -1;
      bit held_v = 0;
      logic [63:0] held_a = '0;
      logic [5:0] held_d = '0;
      logic [63:0] last_wb = '0;
      string at = (atag == "") ? mode_tag(mode) : atag;
      build(vl, mode, wc, imm, base, sm, dm);
      @(negedge clk);
      vl_i = 7'(vl); mode_i = 2'(mode); wc_i = 2'(wc); imm_i = imm; base_i = base;
      sm_i = sm; dm_i = dm; upd_i = upd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc < 400; cyc++) begin
         req_ready = (($urandom % 100) < rdy_pct);
         if (poke && cyc == 1) begin
            start = 1'b1; vl_i = 7'd3; mode_i = 2'd3; base_i = ~base; sm_i = '0;
         end else if (poke && cyc == 2) begin
            start = 1'b0;
         end
         #1;
         if (held_v)
            chk(req_valid && req_addr == held_a && req_dst_idx == held_d, "R8 hold", req_addr, held_a);
         held_v = 0;
         if (done) begin
            fin = 1;
            done_cyc = cyc;
            break;
         end
         if (req_valid) begin
            if (k >= e_n) begin
               chk(0, "R6 extra request", 64'(k), 64'(e_n));
            end else begin
               chk(req_addr == e_addr[k], at, req_addr, e_addr[k]);
               chk(int'(req_dst_idx) == e_dst[k], poke ? "R10 dst" : "R5 dst", 64'(req_dst_idx), 64'(e_dst[k]));
               chk(int'(src_idx) == e_src[k], "R5 src", 64'(src_idx), 64'(e_src[k]));
               if (req_ready) begin
                  chk(wb_valid == upd, "R9 wb_valid", 64'(wb_valid), 64'(upd));
                  if (upd) begin
                     chk(wb_addr == e_addr[k], "R9 wb_addr", wb_addr, e_addr[k]);
                     chk(int'(wb_elem) == ((mode == 0) ? e_src[k] : 0), "R9 wb_elem",
                         64'(wb_elem), 64'((mode == 0) ? e_src[k] : 0));
                     last_wb = wb_addr;
                  end
                  k++;
               end else begin
                  held_v = 1; held_a = req_addr; held_d = req_dst_idx;
               end
            end
         end
         @(negedge clk);
      end
      start = 1'b0;
      if (!fin) begin
         chk(0, "R6 no done (op watchdog)", 64'(k), 64'(e_n));
      end else begin
         chk(k == e_n, "R6 count", 64'(k), 64'(e_n));
         if (vl == 0) chk(done_cyc == 0 && k == 0, "R7 zero length", 64'(done_cyc), 64'd0);
         if (upd && e_n > 0) chk(last_wb == e_addr[e_n-1], "R9 last base", last_wb, e_addr[e_n-1]);
         @(negedge clk);
         #1;
         chk(!busy && !done, "R6 idle after done", {62'd0, busy, done}, 64'd0);
      end
      req_ready = 1'b0;
   endtask

   initial begin
      #600000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!busy && !req_valid && !done, "R12 reset idle", {61'd0, busy, req_valid, done}, 64'd0);

      // R7: zero length
      run_op(0, 2, 3, 16'h0010, 64'h1000, '1, '1, 1, 100, 0, "");
      // R1: unit stride dense, doubleword, no backpressure
      run_op(64, 2, 3, 16'h7777, 64'h0000_0000_8000_0000, '1, '1, 0, 100, 0, "");
      // R1: unit stride byte width with heavy backpressure (R8)
      run_op(20, 2, 0, 16'h0000, 64'h0000_0000_0000_0100, '1, '1, 1, 30, 0, "");
      // R11: negative immediate wraps below zero
      run_op(10, 1, 0, 16'hFFF0, 64'h0000_0000_0000_0020, '1, '1, 1, 70, 0, "R11 wrap");
      // R11: splat wrapping past top of address space
      run_op(5, 3, 0, 16'h0040, 64'hFFFF_FFFF_FFFF_FFF0, 64'h15, '1, 1, 80, 0, "R11 wrap");
      // R2: indirect, sparse source, update back to per-element base
      run_op(32, 0, 2, 16'hFF80, 64'h0, 64'hA5A5_0F0F_3C3C_9999, 64'h0000_0000_FFFF_0001, 1, 60, 0, "");
      // R5: destination mask exhausts first
      run_op(16, 3, 1, 16'h0004, 64'h4000, '1, 64'h0000_0000_0000_0101, 1, 90, 0, "");
      // R5: source mask exhausts first, element stride
      run_op(40, 1, 0, 16'h0018, 64'h9000, 64'h0000_0080_0000_0002, '1, 1, 90, 0, "");
      // R10: start while busy is ignored
      run_op(64, 2, 1, 16'h0000, 64'h2000, '1, '1, 1, 50, 1, "");

      for (int t = 0; t < 60; t++) begin
         int vl = $urandom % 65;
         int md = $urandom % 4;
         int wc = $urandom % 4;
         logic [15:0] im = 16'($urandom);
         logic [63:0] bs = {$urandom, $urandom};
         logic [63:0] sm = {$urandom, $urandom};
         logic [63:0] dm = {$urandom, $urandom};
         int shape = $urandom % 4;
         if (shape == 1) sm = '1;
         if (shape == 2) dm = dm & {$urandom, $urandom} & {$urandom, $urandom};
         run_op(vl, md, wc, im, bs, sm, dm, 1'($urandom), 20 + ($urandom % 81), 0, "");
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule